// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. It has a four-wire serial interface (test clock, mode select, data in, data out) and the standard sixteen-state controller. The controller routes one of four shift registers between the data input and the data output: a 3-bit instruction register, a 1-bit bypass cell, a 32-bit identification register and a boundary register whose length is a parameter. The boundary register captures the level on each observed pin. Its parallel update stage drives a bank of outputs toward the pad logic. A separate flag tells the core to release its outputs.

There is no dedicated test-reset pin. The port returns to Test-Logic-Reset when the mode select is held high, or when the chip-level power-on reset `por_n` is asserted. In either case the identification instruction becomes current. All serial traffic is plain pin-level signalling. There is no valid/ready stream, so no back-pressure rules apply. The serial bits are paced only by the test clock.

Top module: `tap_port`

## Requirements
- R1: While `por_n` is low, the controller sits in Test-Logic-Reset, the current instruction is IDCODE (001), `tdo_oe`, `core_hiz` and `pin_out` are all 0. The first data scan after release returns `ID_CODE`.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. Entering that state makes IDCODE the current instruction. Four such edges started from Shift-DR do not reach it.
- R3: The controller follows the standard sixteen-state transition graph. From Run-Test/Idle, `tms` = 1,0,0 reaches Shift-DR, and 1,1,0,0 reaches Shift-IR. `tms` = 1 from either shift state leaves to its Exit1 state.
- R4: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R5: Capture-IR loads the instruction shift stage with 001 (bits 1:0 = 01, bit 2 = 0). Shift-IR shifts it out least significant bit first, while `tdi` enters at bit 2.
- R6: The shifted instruction becomes current only on the edge that enters Update-IR. While the instruction is being shifted and in Exit1-IR, the previous instruction stays in force.
- R7: Opcode map: 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD, 111 BYPASS. The unassigned codes 011, 101 and 110 select the bypass cell.
- R8: The bypass path captures 0 in Capture-DR and gives a one-cell delay from `tdi` to `tdo` in Shift-DR.
- R9: Under IDCODE, Capture-DR loads `ID_CODE`, which shifts out bit 0 first, with a 32-cell path length.
- R10: Under 000, 010 and 100, Capture-DR loads cell i of the boundary register with `pin_in[i]` when `PIN_MASK[i]` is 1, and with constant 1 otherwise. Cell 0 is nearest `tdo` and the path length is `BSR_LEN`.
- R11: On entry to Update-DR under 000, 010 or 100, `pin_out` takes the boundary shift contents. Under every other instruction, `pin_out` keeps its value across a full data scan.
- R12: `core_hiz` is 1 exactly while SAMPLE-Z (010) is the current instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Chip power-on reset, active low, asynchronous |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for the `tdo` pad |
| pin_in | input | BSR_LEN | Levels captured from the observed pins |
| pin_out | output | BSR_LEN | Boundary update stage toward the pad logic |
| core_hiz | output | 1 | Asks the core to float its outputs |

## Verification
The bench builds the port with an 8-cell boundary register. Two of its cells, 2 and 7, are pin-less placeholders, and it uses a distinctive 32-bit identification constant. With that size, a single 40-bit data scan runs past the end of every register. It therefore exposes the path length, the capture value and the shifted-through input for all eight opcodes in one sweep. The sweep also covers the reserved codes and the placeholder cells that capture 1. Because `ID_CODE` differs from the boundary contents in every byte, a wrong register selection shows up in the scan-out. The sweep ends with a mode-select reset that is stopped one edge short and then completed.

// File: rtl/tapx_pkg.sv
`timescale 1ns/1ps
package tapx_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PSDR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PSIR, S_EX2IR, S_UPIR
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_PRELOAD = 3'b100;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BND} dr_sel_e;

  function automatic dr_sel_e decode_op(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:                          return DR_ID;
      OP_EXTEST, OP_SAMPLEZ, OP_PRELOAD:  return DR_BND;
      default:                            return DR_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tapx_fsm.sv
`timescale 1ns/1ps
module tapx_fsm
  import tapx_pkg::*;
(
  input  logic       por_n,
  input  logic       tck,
  input  logic       tms,
  output tap_state_e st,
  output tap_state_e st_nxt
);

  always_comb begin
    case (st)
      S_TLR:   st_nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   st_nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: st_nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: st_nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  st_nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: st_nxt = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  st_nxt = tms ? S_EX2DR : S_PSDR;
      S_EX2DR: st_nxt = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  st_nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: st_nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: st_nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  st_nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: st_nxt = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  st_nxt = tms ? S_EX2IR : S_PSIR;
      S_EX2IR: st_nxt = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  st_nxt = tms ? S_SELDR : S_RTI;
      default: st_nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) st <= S_TLR;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/tapx_ir.sv
`timescale 1ns/1ps
module tapx_ir
  import tapx_pkg::*;
(
  input  logic            por_n,
  input  logic            tck,
  input  logic            tdi,
  input  tap_state_e      st,
  input  tap_state_e      st_nxt,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sr
);

  localparam logic [IR_W-1:0] CAP_VAL = IR_W'(1);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr <= '0;
    end else if (st == S_CAPIR) begin
      ir_sr <= CAP_VAL;
    end else if (st == S_SHIR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  // current instruction: changes only on entry to Update-IR or Test-Logic-Reset
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_q <= OP_IDCODE;
    end else if (st_nxt == S_TLR) begin
      ir_q <= OP_IDCODE;
    end else if (st_nxt == S_UPIR && st != S_UPIR) begin
      ir_q <= ir_sr;
    end
  end

endmodule

// File: rtl/tapx_dr.sv
`timescale 1ns/1ps
module tapx_dr
  import tapx_pkg::*;
#(
  parameter int                  BSR_LEN  = 16,
  parameter logic [BSR_LEN-1:0]  PIN_MASK = {1'b0, {(BSR_LEN-1){1'b1}}},
  parameter logic [31:0]         ID_CODE  = 32'h0A51_C0DF
)(
  input  logic               por_n,
  input  logic               tck,
  input  logic               tdi,
  input  tap_state_e         st,
  input  tap_state_e         st_nxt,
  input  logic [IR_W-1:0]    op,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               dr_lsb
);

  dr_sel_e            sel;
  logic               byp_q;
  logic [31:0]        id_sr;
  logic [BSR_LEN-1:0] bnd_sr;
  logic [BSR_LEN-1:0] bnd_cap;

  assign sel = decode_op(op);

  // placeholder cells capture a constant 1
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (PIN_MASK[i]) begin : g_pin
      assign bnd_cap[i] = pin_in[i];
    end else begin : g_fix
      assign bnd_cap[i] = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q  <= 1'b0;
      id_sr  <= '0;
      bnd_sr <= '0;
    end else if (st == S_CAPDR) begin
      case (sel)
        DR_ID:   id_sr  <= ID_CODE;
        DR_BND:  bnd_sr <= bnd_cap;
        default: byp_q  <= 1'b0;
      endcase
    end else if (st == S_SHDR) begin
      case (sel)
        DR_ID:   id_sr  <= {tdi, id_sr[31:1]};
        DR_BND:  bnd_sr <= {tdi, bnd_sr[BSR_LEN-1:1]};
        default: byp_q  <= tdi;
      endcase
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)
      pin_out <= '0;
    else if (st_nxt == S_UPDR && st != S_UPDR && sel == DR_BND)
      pin_out <= bnd_sr;
  end

  always_comb begin
    case (sel)
      DR_ID:   dr_lsb = id_sr[0];
      DR_BND:  dr_lsb = bnd_sr[0];
      default: dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tapx_pkg::*;
#(
  parameter int                  BSR_LEN  = 16,
  parameter logic [BSR_LEN-1:0]  PIN_MASK = {1'b0, {(BSR_LEN-1){1'b1}}},
  parameter logic [31:0]         ID_CODE  = 32'h0A51_C0DF
)(
  input  logic               por_n,
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               core_hiz
);

  tap_state_e      st;
  tap_state_e      st_nxt;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_sr;
  logic            dr_lsb;

  tapx_fsm u_fsm (
    .por_n(por_n), .tck(tck), .tms(tms), .st(st), .st_nxt(st_nxt)
  );

  tapx_ir u_ir (
    .por_n(por_n), .tck(tck), .tdi(tdi), .st(st), .st_nxt(st_nxt),
    .ir_q(ir_q), .ir_sr(ir_sr)
  );

  tapx_dr #(.BSR_LEN(BSR_LEN), .PIN_MASK(PIN_MASK), .ID_CODE(ID_CODE)) u_dr (
    .por_n(por_n), .tck(tck), .tdi(tdi), .st(st), .st_nxt(st_nxt),
    .op(ir_q), .pin_in(pin_in), .pin_out(pin_out), .dr_lsb(dr_lsb)
  );

  assign core_hiz = (ir_q == OP_SAMPLEZ);

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == S_SHIR) || (st == S_SHDR);
      if (st == S_SHIR)      tdo <= ir_sr[0];
      else if (st == S_SHDR) tdo <= dr_lsb;
    end
  end

endmodule

// File: rtl/tapx_chk.sv
`timescale 1ns/1ps
module tapx_chk
  import tapx_pkg::*;
(
  input logic            por_n,
  input logic            tck,
  input logic            tms,
  input tap_state_e      st,
  input logic [IR_W-1:0] ir,
  input logic [IR_W-1:0] ir_sr,
  input logic            core_hiz
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)   hi_cnt <= '0;
    else if (!tms) hi_cnt <= '0;
    else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
  end

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
    (hi_cnt >= 3'd5) |-> (st == S_TLR));

  // R2
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_TLR) |-> (ir == OP_IDCODE));

  // R5
  ir_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_CAPIR) |=> (ir_sr[1:0] == 2'b01));

  // R6
  ir_update_chk: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir) |-> (st == S_UPIR || st == S_TLR));

  // R12
  hiz_rise_chk: assert property (@(posedge tck) disable iff (!por_n)
    $rose(core_hiz) |-> (st == S_UPIR));

endmodule

bind tap_port tapx_chk u_chk (
  .por_n(por_n), .tck(tck), .tms(tms), .st(st),
  .ir(ir_q), .ir_sr(ir_sr), .core_hiz(core_hiz)
);

// File: tb/test_tap_port.sv
`timescale 1ns/1ps
module test_tap_port;

  localparam int          N    = 8;
  localparam logic [N-1:0] MASK = 8'b0111_1011;
  localparam logic [31:0] IDV  = 32'h8D3C_4A17;
  localparam int          SL   = 40;

  logic por_n = 1'b0;
  logic tck   = 1'b0;
  logic tms   = 1'b1;
  logic tdi   = 1'b1;
  logic tdo, tdo_oe, core_hiz;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic tdo_s, tdo_pre;

  always #2 tck = ~tck;

  tap_port #(.BSR_LEN(N), .PIN_MASK(MASK), .ID_CODE(IDV)) i_tap_port (
    .por_n(por_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .pin_out(pin_out), .core_hiz(core_hiz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #0.5 tdo_pre = tdo;
    @(negedge tck); #0.5 tdo_s = tdo;
  endtask

  // from Run-Test/Idle; returns captured instruction bits; ends in Run-Test/Idle
  task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
    logic hz0;
    hz0 = core_hiz;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    chk(tdo_oe == 1'b1, "R3 shift-ir reached", tdo_oe, 1);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo_s;
      step(i == 2, op[i]);
    end
    chk(core_hiz == hz0, "R6 instruction held in Exit1-IR", core_hiz, hz0);
    step(1, 0);
    step(0, 0);
  endtask

  task automatic dr_scan(input logic [SL-1:0] din, output logic [SL-1:0] dout);
    int edge_bad;
    logic prev;
    edge_bad = 0;
    step(1, 0); step(0, 0); step(0, 0);
    chk(tdo_oe == 1'b1, "R4 tdo_oe in shift-dr", tdo_oe, 1);
    for (int i = 0; i < SL; i++) begin
      dout[i] = tdo_s;
      prev = tdo_s;
      step(i == SL - 1, din[i]);
      if (i < SL - 1 && tdo_pre !== prev) edge_bad++;
    end
    chk(edge_bad == 0, "R4 tdo stable across rising edge", edge_bad, 0);
    chk(tdo_oe == 1'b0, "R4 tdo_oe off in Exit1-DR", tdo_oe, 0);
    step(1, 0);
    step(0, 0);
  endtask

  initial begin
    #(4 * 20000);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0]    cap;
    logic [SL-1:0] din, dout, exp;
    logic [N-1:0]  pins, pbefore, capv;

    repeat (3) @(posedge tck);
    @(negedge tck); #0.5;
    chk(tdo_oe == 0, "R1 tdo_oe in reset", tdo_oe, 0);
    chk(core_hiz == 0, "R1 core_hiz in reset", core_hiz, 0);
    chk(pin_out == '0, "R1 pin_out in reset", pin_out, 0);
    por_n = 1'b1;
    step(0, 0);
    dr_scan('0, dout);
    chk(dout[31:0] == IDV, "R1 IDCODE after power-up", dout[31:0], IDV);

    for (int op = 0; op < 8; op++) begin
      pins   = N'(op * 37 + 90);
      pin_in = pins;
      ir_scan(3'(op), cap);
      chk(cap == 3'b001, "R5 captured instruction", cap, 3'b001);
      chk(core_hiz == (op == 2), "R12 core_hiz per opcode", core_hiz, (op == 2));
      pbefore = pin_out;
      din = {SL{1'b0}} ^ 40'hA5_3C96_E1D2 ^ (40'(op) * 40'h13_5791_3579);
      dr_scan(din, dout);
      capv = (pins & MASK) | ~MASK;
      if (op == 1) begin
        for (int i = 0; i < SL; i++) exp[i] = (i < 32) ? IDV[i] : din[i-32];
        chk(dout == exp, "R9 id path", dout, exp);
        chk(pin_out == pbefore, "R11 pin_out held (id)", pin_out, pbefore);
      end else if (op == 0 || op == 2 || op == 4) begin
        for (int i = 0; i < SL; i++) exp[i] = (i < N) ? capv[i] : din[i-N];
        chk(dout == exp, "R10 boundary path (R7)", dout, exp);
        chk(pin_out == din[SL-N +: N], "R11 update", pin_out, din[SL-N +: N]);
      end else begin
        for (int i = 0; i < SL; i++) exp[i] = (i == 0) ? 1'b0 : din[i-1];
        chk(dout == exp, "R8 bypass path (R7)", dout, exp);
        chk(pin_out == pbefore, "R11 pin_out held (bypass)", pin_out, pbefore);
      end
      chk(core_hiz == (op == 2), "R12 core_hiz after scan", core_hiz, (op == 2));
    end

    ir_scan(3'b010, cap);
    chk(core_hiz == 1, "R12 SAMPLE-Z loaded", core_hiz, 1);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (4) step(1, 0);
    chk(core_hiz == 1, "R2 four tms-high edges short of reset", core_hiz, 1);
    step(1, 0);
    chk(core_hiz == 0, "R2 fifth tms-high edge resets", core_hiz, 0);
    step(0, 0);
    dr_scan('0, dout);
    chk(dout[31:0] == IDV, "R2 IDCODE after tms reset", dout[31:0], IDV);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule